// File: doc/BRIEF.md
# Memory Order Violation Detector

This block watches loads and stores that a dynamic scheduler has moved ahead of one another, and reports when such a move broke program order. Each access carries a scheduling-time order number, drawn from a counter that restarts whenever the scheduling window empties and advances on every memory access placed. Each access also carries a cross flag, which the scheduler sets when the access shares its wide instruction with a store or with the copy half of a split store.

Every cycle, the detector takes one wide instruction of up to `LANES` memory accesses. Each access is compared against the other accesses in the same wide instruction and, by address, against two small associative lists. One list holds earlier cross-flagged loads and the other holds earlier cross-flagged stores. A violation exists when an access matches an address that belongs to an access with a larger order number, which means it was scheduled after that access but now runs first. A load only has to be ordered against stores. A store must be ordered against both loads and stores. A matching address with a smaller or equal order number is legal.

Violations raise a registered exception. A synchronous clear empties both lists at a block boundary or when recovery starts. The reset `rst_n` is asynchronous and active low, and must be released synchronously to `clk`.

Top module: `mem_order_alias_det`

## Requirements
- R1: After reset, `alias_exc` and `list_full` are low and both lists are empty.
- R2: A valid load in lane i raises `alias_exc` in the following cycle if a valid store in another lane of the same wide instruction has the same address and a larger order number. Two loads are never checked against each other. `acc_st` bit i is 1 for a store and 0 for a load.
- R3: A valid store in lane i raises `alias_exc` in the following cycle if a valid load or store in another lane of the same wide instruction has the same address and a larger order number.
- R4: A valid load raises `alias_exc` in the following cycle if the store list holds an entry with the same address and a larger order number. The load list is never searched for a load.
- R5: A valid store raises `alias_exc` in the following cycle if either list holds an entry with the same address and a larger order number.
- R6: An access produces no exception if no address matches, or if every match has an order number equal to or smaller than its own.
- R7: Only valid accesses with the cross bit set are recorded. A cross load goes into the load list and a cross store goes into the store list, in lane order. A recorded access is searched starting in the next cycle. Accesses in the same cycle are compared only through R2 and R3.
- R8: A cross access that finds its list already holding `DEPTH` entries is not recorded. It raises `alias_exc` in the following cycle and sets `list_full`, which stays high until a clear.
- R9: When `clr` is high, both lists and `list_full` are emptied at the next edge. The accesses presented in that cycle are neither checked nor recorded, so `alias_exc` is low in the following cycle.
- R10: `alias_exc` is registered. It is high for exactly those cycles that follow a cycle holding a violation or an overflow.
- R11: Lane i uses `acc_addr[i*AW +: AW]` and `acc_ord[i*OW +: OW]`. Order numbers compare as unsigned values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Empty both lists and the full flag |
| acc_vld | input | LANES | Lane holds a memory access |
| acc_st | input | LANES | 1 = store, 0 = load |
| acc_cross | input | LANES | Record this access in its list |
| acc_addr | input | LANES*AW | Lane addresses, lane 0 in the low bits |
| acc_ord | input | LANES*OW | Lane order numbers, lane 0 in the low bits |
| alias_exc | output | 1 | Registered order-violation exception |
| list_full | output | 1 | Sticky overflow flag |

## Verification
The same-instruction sweep runs every pairing of load and store kinds, with equal and unequal addresses and every pair of small order numbers. It shows that the direction of the order comparison is correct, that load/load pairs are excluded, and that equal order numbers are legal. A second sweep places one recorded entry of each kind and probes it with each access kind over the same order grid. This shows which list each kind searches. Directed sequences fill a list to capacity, one entry at a time and two in one cycle, to expose the overflow boundary and the stickiness of the full flag. Further sequences present non-cross accesses and accesses in a clear cycle, then probe afterwards to show that these accesses left no entry behind.

// File: rtl/alias_det_pkg.sv
package alias_det_pkg;
  typedef enum logic {
    ACC_LOAD  = 1'b0,
    ACC_STORE = 1'b1
  } acc_kind_e;
endpackage

// File: rtl/alias_ord_list.sv
// Append-only associative list of recorded accesses, with a younger-match search.
module alias_ord_list #(
  parameter int LANES = 2,
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int OW    = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic [LANES-1:0]      wr_en,
  input  logic [LANES*AW-1:0]   lane_addr,
  input  logic [LANES*OW-1:0]   lane_ord,
  output logic [LANES-1:0]      hit_younger,
  output logic                  ovf,
  output logic                  full
);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int PW  = $clog2(DEPTH + LANES + 1);
  localparam int LSW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [AW-1:0]  ent_addr [DEPTH];
  logic [OW-1:0]  ent_ord  [DEPTH];
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           full_q, full_d;
  logic [PW-1:0]  fill_ptr;
  logic [PW-1:0]  slot [LANES];
  logic [DEPTH-1:0] ent_we;
  logic [LSW-1:0] ent_src [DEPTH];

  // Slot assignment, in lane order
  always_comb begin
    fill_ptr = PW'(cnt_q);
    ovf      = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      slot[i] = fill_ptr;
      if (wr_en[i] && !clr) begin
        if (fill_ptr >= PW'(DEPTH)) ovf = 1'b1;
        else fill_ptr = fill_ptr + PW'(1);
      end
    end
  end

  always_comb begin
    for (int d = 0; d < DEPTH; d++) begin
      ent_we[d]  = 1'b0;
      ent_src[d] = '0;
      for (int i = 0; i < LANES; i++) begin
        if (wr_en[i] && !clr && slot[i] == PW'(d)) begin
          ent_we[d]  = 1'b1;
          ent_src[d] = LSW'(i);
        end
      end
    end
  end

  // Next state of the control registers
  always_comb begin
    cnt_d  = clr ? '0 : CW'(fill_ptr);
    full_d = clr ? 1'b0 : (full_q | ovf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      full_q <= full_d;
    end
  end

  for (genvar d = 0; d < DEPTH; d++) begin : g_ent
    always_ff @(posedge clk) begin
      if (ent_we[d]) begin
        ent_addr[d] <= lane_addr[ent_src[d]*AW +: AW];
        ent_ord[d]  <= lane_ord[ent_src[d]*OW +: OW];
      end
    end
  end

  // Associative search: same address, entry scheduled later than the query
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      hit_younger[i] = 1'b0;
      for (int d = 0; d < DEPTH; d++) begin
        if ((CW'(d) < cnt_q) &&
            ent_addr[d] == lane_addr[i*AW +: AW] &&
            lane_ord[i*OW +: OW] < ent_ord[d])
          hit_younger[i] = 1'b1;
      end
    end
  end

  assign full = full_q;
endmodule

// File: rtl/alias_lane_cmp.sv
// Order comparison between the accesses of one wide instruction.
module alias_lane_cmp
  import alias_det_pkg::*;
#(
  parameter int LANES = 2,
  parameter int AW    = 16,
  parameter int OW    = 6
) (
  input  logic [LANES-1:0]    vld,
  input  logic [LANES-1:0]    st,
  input  logic [LANES*AW-1:0] addr,
  input  logic [LANES*OW-1:0] ord,
  output logic [LANES-1:0]    intra_viol
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      intra_viol[i] = 1'b0;
      for (int j = 0; j < LANES; j++) begin
        if (j != i && vld[i] && vld[j] &&
            addr[i*AW +: AW] == addr[j*AW +: AW] &&
            ord[i*OW +: OW] < ord[j*OW +: OW] &&
            (acc_kind_e'(st[i]) == ACC_STORE || acc_kind_e'(st[j]) == ACC_STORE))
          intra_viol[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mem_order_alias_det.sv
module mem_order_alias_det
  import alias_det_pkg::*;
#(
  parameter int LANES = 2,
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int OW    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic [LANES-1:0]    acc_vld,
  input  logic [LANES-1:0]    acc_st,
  input  logic [LANES-1:0]    acc_cross,
  input  logic [LANES*AW-1:0] acc_addr,
  input  logic [LANES*OW-1:0] acc_ord,
  output logic                alias_exc,
  output logic                list_full
);
  logic [LANES-1:0] ld_wr, st_wr;
  logic [LANES-1:0] ld_hit, st_hit, intra_viol, viol;
  logic             ld_ovf, st_ovf, ld_full, st_full;
  logic             exc_q, exc_d;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      ld_wr[i] = acc_vld[i] && acc_cross[i] && !clr && acc_kind_e'(acc_st[i]) == ACC_LOAD;
      st_wr[i] = acc_vld[i] && acc_cross[i] && !clr && acc_kind_e'(acc_st[i]) == ACC_STORE;
    end
  end

  alias_ord_list #(.LANES(LANES), .DEPTH(DEPTH), .AW(AW), .OW(OW)) u_ld_list (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(ld_wr),
    .lane_addr(acc_addr), .lane_ord(acc_ord),
    .hit_younger(ld_hit), .ovf(ld_ovf), .full(ld_full));

  alias_ord_list #(.LANES(LANES), .DEPTH(DEPTH), .AW(AW), .OW(OW)) u_st_list (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(st_wr),
    .lane_addr(acc_addr), .lane_ord(acc_ord),
    .hit_younger(st_hit), .ovf(st_ovf), .full(st_full));

  alias_lane_cmp #(.LANES(LANES), .AW(AW), .OW(OW)) u_lane_cmp (
    .vld(acc_vld), .st(acc_st), .addr(acc_addr), .ord(acc_ord),
    .intra_viol(intra_viol));

  // Loads search the store list only; stores search both lists
  always_comb begin
    for (int i = 0; i < LANES; i++)
      viol[i] = acc_vld[i] &&
                (intra_viol[i] || st_hit[i] ||
                 (acc_kind_e'(acc_st[i]) == ACC_STORE && ld_hit[i]));
    exc_d = !clr && ((|viol) || ld_ovf || st_ovf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exc_q <= 1'b0;
    else        exc_q <= exc_d;
  end

  assign alias_exc = exc_q;
  assign list_full = ld_full | st_full;
endmodule

// File: rtl/mem_order_alias_det_chk.sv
module mem_order_alias_det_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic [LANES-1:0] acc_vld,
  input logic             alias_exc,
  input logic             list_full
);
  // R9
  clr_quiet_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !alias_exc);
  // R9
  clr_empties_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !list_full);
  // R8
  full_raises_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(list_full) |-> alias_exc);
  // R8
  full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (list_full && !clr) |=> list_full);
  // R10
  idle_no_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld == '0) |=> !alias_exc);
endmodule

bind mem_order_alias_det mem_order_alias_det_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .acc_vld(acc_vld),
  .alias_exc(alias_exc), .list_full(list_full));

// File: tb/mem_order_alias_det_tb.sv
module mem_order_alias_det_tb;
  localparam int D = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       clr;
  logic [1:0] vld, st, cr;
  logic [7:0] addr, ord;
  logic       alias_exc, list_full;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0] m_ld_a [D];
  logic [3:0] m_ld_o [D];
  logic [3:0] m_st_a [D];
  logic [3:0] m_st_o [D];
  int  m_ld_n = 0, m_st_n = 0;
  logic m_full = 1'b0;

  always #5 clk = ~clk;

  mem_order_alias_det #(.LANES(2), .DEPTH(D), .AW(4), .OW(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .acc_vld(vld), .acc_st(st),
    .acc_cross(cr), .acc_addr(addr), .acc_ord(ord),
    .alias_exc(alias_exc), .list_full(list_full));

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic [1:0] v, input logic [1:0] s,
                      input logic [1:0] x, input logic [3:0] a0, input logic [3:0] a1,
                      input logic [3:0] o0, input logic [3:0] o1, input string tag);
    logic [3:0] la [2];
    logic [3:0] lo [2];
    logic e;
    la[0] = a0; la[1] = a1; lo[0] = o0; lo[1] = o1;
    clr = c; vld = v; st = s; cr = x; addr = {a1, a0}; ord = {o1, o0};
    e = 1'b0;
    if (c) begin
      m_ld_n = 0; m_st_n = 0; m_full = 1'b0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (v[i]) begin
          for (int j = 0; j < 2; j++)
            if (j != i && v[j] && la[j] == la[i] && lo[i] < lo[j] && (s[i] || s[j])) e = 1'b1;
          for (int k = 0; k < m_st_n; k++)
            if (m_st_a[k] == la[i] && lo[i] < m_st_o[k]) e = 1'b1;
          if (s[i])
            for (int k = 0; k < m_ld_n; k++)
              if (m_ld_a[k] == la[i] && lo[i] < m_ld_o[k]) e = 1'b1;
        end
      end
      for (int i = 0; i < 2; i++) begin
        if (v[i] && x[i]) begin
          if (s[i]) begin
            if (m_st_n < D) begin m_st_a[m_st_n] = la[i]; m_st_o[m_st_n] = lo[i]; m_st_n++; end
            else begin e = 1'b1; m_full = 1'b1; end
          end else begin
            if (m_ld_n < D) begin m_ld_a[m_ld_n] = la[i]; m_ld_o[m_ld_n] = lo[i]; m_ld_n++; end
            else begin e = 1'b1; m_full = 1'b1; end
          end
        end
      end
    end
    @(posedge clk);
    #1;
    check(tag, "alias_exc", alias_exc, e);
    check(tag, "list_full", list_full, m_full);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 2'b00, 2'b00, 2'b00, 4'd0, 4'd0, 4'd0, 4'd0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; vld = '0; st = '0; cr = '0; addr = '0; ord = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    check("R1", "alias_exc", alias_exc, 1'b0);
    check("R1", "list_full", list_full, 1'b0);
    // R1: lists empty, a store probe with order 0 hits nothing
    step(1'b0, 2'b01, 2'b01, 2'b00, 4'd1, 4'd0, 4'd0, 4'd0, "R1");

    // R2, R3, R6, R11: same-instruction sweep, nothing recorded
    for (int t = 0; t < 4; t++)
      for (int ae = 0; ae < 2; ae++)
        for (int o0 = 0; o0 < 4; o0++)
          for (int o1 = 0; o1 < 4; o1++)
            step(1'b0, 2'b11, 2'(t), 2'b00, 4'd5, ae ? 4'd5 : 4'd6,
                 4'(o0), 4'(o1), (t == 0) ? "R2" : "R3");
    idle("R10");

    // R4, R5, R6: one recorded entry of each kind, probed by each kind
    for (int et = 0; et < 2; et++)
      for (int pt = 0; pt < 2; pt++)
        for (int ae = 0; ae < 2; ae++)
          for (int eo = 0; eo < 4; eo++)
            for (int po = 0; po < 4; po++) begin
              step(1'b1, 2'b00, 2'b00, 2'b00, 4'd0, 4'd0, 4'd0, 4'd0, "R9");
              step(1'b0, 2'b01, 2'(et), 2'b01, 4'd3, 4'd0, 4'(eo), 4'd0, "R7");
              step(1'b0, 2'b10, {1'(pt), 1'b0}, 2'b00, 4'd0, ae ? 4'd3 : 4'd9,
                   4'd0, 4'(po), pt ? "R5" : "R4");
            end

    // R7: non-cross store leaves no entry
    step(1'b1, 2'b00, 2'b00, 2'b00, 4'd0, 4'd0, 4'd0, 4'd0, "R9");
    step(1'b0, 2'b01, 2'b01, 2'b00, 4'd3, 4'd0, 4'd3, 4'd0, "R7");
    step(1'b0, 2'b01, 2'b00, 2'b00, 4'd3, 4'd0, 4'd0, 4'd0, "R7");
    // R7: two cross stores in one cycle, both recorded, both probed next cycle
    step(1'b0, 2'b11, 2'b11, 2'b11, 4'd7, 4'd8, 4'd2, 4'd3, "R7");
    step(1'b0, 2'b01, 2'b00, 2'b00, 4'd8, 4'd0, 4'd1, 4'd0, "R7");
    step(1'b0, 2'b01, 2'b00, 2'b00, 4'd7, 4'd0, 4'd1, 4'd0, "R7");

    // R8: fill the load list one per cycle, then overflow
    step(1'b1, 2'b00, 2'b00, 2'b00, 4'd0, 4'd0, 4'd0, 4'd0, "R9");
    for (int k = 0; k < D; k++)
      step(1'b0, 2'b01, 2'b00, 2'b01, 4'(k), 4'd0, 4'(k), 4'd0, "R8");
    step(1'b0, 2'b01, 2'b00, 2'b01, 4'd9, 4'd0, 4'd9, 4'd9, "R8");
    idle("R10");
    idle("R8");
    // R9: clear empties the lists and the flag
    step(1'b1, 2'b00, 2'b00, 2'b00, 4'd0, 4'd0, 4'd0, 4'd0, "R9");
    step(1'b0, 2'b01, 2'b01, 2'b00, 4'd0, 4'd0, 4'd0, 4'd0, "R9");

    // R8: two cross stores in one cycle with one slot left
    step(1'b1, 2'b00, 2'b00, 2'b00, 4'd0, 4'd0, 4'd0, 4'd0, "R9");
    for (int k = 0; k < D - 1; k++)
      step(1'b0, 2'b01, 2'b01, 2'b01, 4'(k), 4'd0, 4'(k), 4'd0, "R8");
    step(1'b0, 2'b11, 2'b11, 2'b11, 4'd10, 4'd11, 4'd5, 4'd6, "R8");
    // R8: the lane-1 store was dropped, the lane-0 store was kept
    step(1'b0, 2'b01, 2'b00, 2'b00, 4'd11, 4'd0, 4'd0, 4'd0, "R8");
    step(1'b0, 2'b01, 2'b00, 2'b00, 4'd10, 4'd0, 4'd0, 4'd0, "R8");

    // R9: accesses in a clear cycle are neither checked nor recorded
    step(1'b1, 2'b11, 2'b10, 2'b11, 4'd5, 4'd5, 4'd0, 4'd3, "R9");
    step(1'b0, 2'b01, 2'b01, 2'b00, 4'd5, 4'd0, 4'd0, 4'd0, "R9");
    step(1'b0, 2'b01, 2'b00, 2'b00, 4'd5, 4'd0, 4'd0, 4'd0, "R9");
    idle("R10");

    finish_run();
  end
endmodule